// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a small two-way set-associative data cache. It sits between a processor load/store port and a memory port that moves whole blocks. It holds 256 data bytes as eight 32-byte lines arranged in four sets of two ways, behind a 12-bit byte address. The processor issues one 64-bit word access at a time over a request/ready handshake. Each access gets a single-cycle response pulse, which carries the word on a load.

A lookup compares the tag against both ways of the indexed set in parallel. A hit is served from the line. A store hit changes only the cached copy and marks the line dirty. On a miss a victim way is chosen. An empty way is taken first; otherwise the way that one recency bit per set marks as least recently used is taken. A dirty victim is first written back to memory as a whole block. The missing block is then read into that way. A store miss allocates the line and merges its word into the filled block, so the line leaves the fill already dirty.

Top module: `wb_assoc_cache`

## Requirements
- R1: A request address splits into tag = addr[11:7], set index = addr[6:5] and word select = addr[4:3] (one of four 64-bit words per block). Address bits [2:0] have no effect on which word is read or written.
- R2: After reset no line is valid. reqReady is 1, rspValid is 0 and memReqValid is 0, and the first access to any block performs one memory block read.
- R3: A load that hits returns the stored word and causes no memory transaction.
- R4: A store that hits updates only the addressed word of the cached line and marks the line dirty. It issues no memory write, and a later load of that word returns the stored value.
- R5: On a miss the victim is an invalid way if the set has one (way 0 before way 1). Otherwise it is the least recently used way. Every hit and every fill makes the accessed way the most recently used.
- R6: A dirty victim is written back once, as a whole block, to memory address {victim tag, index, 5'b0}. A clean or invalid victim causes no write-back.
- R7: A miss reads the block at {request tag, index, 5'b0} into the victim way. The line becomes valid with the new tag and is clean unless R8 applies.
- R8: A store miss allocates the line: after the fill, the store word replaces the addressed word of the filled block and the line is marked dirty. The other words keep their memory values.
- R9: A load miss returns the requested word of the newly filled block.
- R10: reqReady is 1 only while the cache is idle. It stays 0 from the cycle after a request is accepted until the cycle after that request's single rspValid pulse.
- R11: When a write-back is needed, the block write completes (memReqValid and memReqReady with memReqWrite=1) before the fill read is presented. The read follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor request present |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 12 | Byte address of the access |
| reqWData | input | 64 | Store data |
| reqReady | output | 1 | Cache can accept a request |
| rspValid | output | 1 | One-cycle response pulse |
| rspRData | output | 64 | Load data, valid with rspValid |
| memReqValid | output | 1 | Memory block transfer requested |
| memReqWrite | output | 1 | 1 = block write-back, 0 = block fill read |
| memAddr | output | 12 | Block-aligned memory address |
| memWData | output | 256 | Write-back block data |
| memReqReady | input | 1 | Memory accepts the transfer; on a read, memRData is valid in the same cycle |
| memRData | input | 256 | Fill block data |

## Verification
On a store miss, the fill and the merge of the store word land on the same clock edge. The installed line must therefore carry memory's block with exactly one word replaced, and it must come out dirty. The bench provokes this with directed and random store misses into sets whose victims are clean or dirty. It then judges the result when that line is later read back word by word and when it is evicted: the write-back block and the follow-up loads must match a reference of memory contents, tags, dirty bits and recency bits that the bench keeps itself.

// File: rtl/cache_pkg.sv
package cache_pkg;
  parameter int ADDR_W = 12;
  parameter int OFF_W  = 5;
  parameter int IDX_W  = 2;
  parameter int WORD_W = 64;
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int SETS    = 1 << IDX_W;
  localparam int BLOCK_W = (1 << OFF_W) * 8;
  localparam int WORDS   = BLOCK_W / WORD_W;
  localparam int WSEL_W  = $clog2(WORDS);
  localparam int BYTE_W  = $clog2(WORD_W / 8);

  typedef enum logic [2:0] {IDLE, LOOKUP, WRITEBACK, FILL, RESPOND} state_t;

  typedef struct packed {
    logic capture;    // latch incoming request
    logic hitAccess;  // lookup hit: touch recency, merge store
    logic wbPhase;    // memory address points at victim
    logic fill;       // install fetched block
  } strobe_t;
endpackage

// File: rtl/cache_dp.sv
module cache_dp
  import cache_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [WORD_W-1:0]   reqWData,
  input  logic [BLOCK_W-1:0]  memRData,
  output logic                hit,
  output logic                victimDirty,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [BLOCK_W-1:0]  memWData,
  output logic [WORD_W-1:0]   rdWord
);
  localparam int NWAY = 2;

  logic                aWrite;
  logic [ADDR_W-1:0]   aAddr;
  logic [WORD_W-1:0]   aData;

  logic [NWAY-1:0]     validArr [SETS];
  logic [NWAY-1:0]     dirtyArr [SETS];
  logic                lruArr   [SETS];
  logic [TAG_W-1:0]    tagArr   [SETS][NWAY];
  logic [BLOCK_W-1:0]  dataArr  [SETS][NWAY];

  logic [TAG_W-1:0]    aTag;
  logic [IDX_W-1:0]    aIdx;
  logic [WSEL_W-1:0]   aWsel;
  logic [NWAY-1:0]     wayHit;
  logic                hitWay;
  logic                victim;
  logic [BLOCK_W-1:0]  fillBlk;

  assign aTag  = aAddr[ADDR_W-1 -: TAG_W];
  assign aIdx  = aAddr[OFF_W +: IDX_W];
  assign aWsel = aAddr[BYTE_W +: WSEL_W];

  for (genvar w = 0; w < NWAY; w++) begin : g_cmp
    assign wayHit[w] = validArr[aIdx][w] && (tagArr[aIdx][w] == aTag);
  end

  assign hit    = |wayHit;
  assign hitWay = wayHit[1];

  always_comb begin
    if (!validArr[aIdx][0])      victim = 1'b0;
    else if (!validArr[aIdx][1]) victim = 1'b1;
    else                         victim = lruArr[aIdx];
  end

  assign victimDirty = validArr[aIdx][victim] && dirtyArr[aIdx][victim];
  assign memWData    = dataArr[aIdx][victim];
  assign memAddr     = strobe.wbPhase ? {tagArr[aIdx][victim], aIdx, {OFF_W{1'b0}}}
                                      : {aTag, aIdx, {OFF_W{1'b0}}};
  assign rdWord      = dataArr[aIdx][hitWay][aWsel*WORD_W +: WORD_W];

  always_comb begin
    fillBlk = memRData;
    if (aWrite) fillBlk[aWsel*WORD_W +: WORD_W] = aData;
  end

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      aWrite <= reqWrite;
      aAddr  <= reqAddr;
      aData  <= reqWData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        dirtyArr[s] <= '0;
        lruArr[s]   <= 1'b0;
      end
    end else if (strobe.hitAccess) begin
      lruArr[aIdx] <= ~hitWay;
      if (aWrite) dirtyArr[aIdx][hitWay] <= 1'b1;
    end else if (strobe.fill) begin
      lruArr[aIdx]           <= ~victim;
      validArr[aIdx][victim] <= 1'b1;
      dirtyArr[aIdx][victim] <= aWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.hitAccess && aWrite) begin
      dataArr[aIdx][hitWay][aWsel*WORD_W +: WORD_W] <= aData;
    end else if (strobe.fill) begin
      dataArr[aIdx][victim] <= fillBlk;
      tagArr[aIdx][victim]  <= aTag;
    end
  end

  // R4
  hit_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hitAccess && aWrite) |=> (hit && dirtyArr[aIdx][hitWay]));

  // R8
  fill_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |=> (hit && (dirtyArr[aIdx][hitWay] == aWrite)));

  // R6
  wb_dirty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wbPhase |-> victimDirty);
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    hit,
  input  logic    victimDirty,
  input  logic    memReqReady,
  output strobe_t strobe,
  output logic    reqReady,
  output logic    rspValid,
  output logic    memReqValid,
  output logic    memReqWrite
);
  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    reqReady    = 1'b0;
    rspValid    = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    case (state)
      IDLE: begin
        reqReady       = 1'b1;
        strobe.capture = reqValid;
        if (reqValid) stateNext = LOOKUP;
      end
      LOOKUP: begin
        if (hit) begin
          strobe.hitAccess = 1'b1;
          stateNext        = RESPOND;
        end else if (victimDirty) begin
          stateNext = WRITEBACK;
        end else begin
          stateNext = FILL;
        end
      end
      WRITEBACK: begin
        strobe.wbPhase = 1'b1;
        memReqValid    = 1'b1;
        memReqWrite    = 1'b1;
        if (memReqReady) stateNext = FILL;
      end
      FILL: begin
        memReqValid = 1'b1;
        if (memReqReady) begin
          strobe.fill = 1'b1;
          stateNext   = RESPOND;
        end
      end
      RESPOND: begin
        rspValid  = 1'b1;
        stateNext = IDLE;
      end
      default: stateNext = IDLE;
    endcase
  end

  // R11
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite && memReqReady) |=> (memReqValid && !memReqWrite));

  // R3
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == LOOKUP && hit) |=> (rspValid && !memReqValid));

  // R10
  rsp_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (reqReady && !rspValid));
endmodule

// File: rtl/wb_assoc_cache.sv
module wb_assoc_cache
  import cache_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [WORD_W-1:0]   reqWData,
  output logic                reqReady,
  output logic                rspValid,
  output logic [WORD_W-1:0]   rspRData,
  output logic                memReqValid,
  output logic                memReqWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [BLOCK_W-1:0]  memWData,
  input  logic                memReqReady,
  input  logic [BLOCK_W-1:0]  memRData
);
  strobe_t strobe;
  logic    hit;
  logic    victimDirty;

  cache_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hit(hit),
    .victimDirty(victimDirty), .memReqReady(memReqReady), .strobe(strobe),
    .reqReady(reqReady), .rspValid(rspValid), .memReqValid(memReqValid),
    .memReqWrite(memReqWrite)
  );

  cache_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWData(reqWData), .memRData(memRData), .hit(hit),
    .victimDirty(victimDirty), .memAddr(memAddr), .memWData(memWData),
    .rdWord(rspRData)
  );
endmodule

// File: tb/wb_assoc_cache_tb_top.sv
module wb_assoc_cache_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqWrite = 1'b0;
  logic [11:0]  reqAddr = '0;
  logic [63:0]  reqWData = '0;
  logic         reqReady;
  logic         rspValid;
  logic [63:0]  rspRData;
  logic         memReqValid;
  logic         memReqWrite;
  logic [11:0]  memAddr;
  logic [255:0] memWData;
  logic         memReqReady = 1'b0;
  logic [255:0] memRData;

  wb_assoc_cache dut_i (.*);

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycle = 0;
  logic [255:0] mem [128];
  int wrCnt = 0, rdCnt = 0, wrCyc = 0, rdCyc = 0;
  logic [11:0] lastWrAddr, lastRdAddr;
  logic [255:0] lastWrData;

  logic [63:0] shadow [128][4];
  logic [1:0]  refValid [4];
  logic [1:0]  refDirty [4];
  logic        refLru   [4];
  logic [4:0]  refTag   [4][2];

  assign memRData = mem[memAddr[11:5]];

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (memReqValid && memReqReady) begin
      if (memReqWrite) begin
        mem[memAddr[11:5]] <= memWData;
        wrCnt <= wrCnt + 1; wrCyc <= cycle;
        lastWrAddr <= memAddr; lastWrData <= memWData;
      end else begin
        rdCnt <= rdCnt + 1; rdCyc <= cycle; lastRdAddr <= memAddr;
      end
    end
  end

  always @(negedge clk) memReqReady <= ($urandom % 3) != 0;

  function automatic logic [63:0] initWord(int blk, int w);
    return {32'hC0DE_0000 + 32'(blk * 4 + w), 32'h5A00_0000 ^ 32'((blk * 4 + w) * 37)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [11:0] addr, logic [63:0] data);
    int idx = addr[6:5];
    int tag = addr[11:7];
    int blk = addr[11:5];
    int ws  = addr[4:3];
    bit expHit = 0, expWb = 0, vic = 0, readyBad = 0, gotRsp = 0;
    logic [11:0] expWbAddr = '0;
    logic [255:0] expWbData = '0;
    int w0 = wrCnt, r0 = rdCnt;
    logic [63:0] got = '0;
    for (int w = 0; w < 2; w++)
      if (refValid[idx][w] && refTag[idx][w] == 5'(tag)) begin expHit = 1; vic = w[0]; end
    if (!expHit) begin
      vic = !refValid[idx][0] ? 1'b0 : !refValid[idx][1] ? 1'b1 : refLru[idx];
      expWb = refValid[idx][vic] && refDirty[idx][vic];
      expWbAddr = {refTag[idx][vic], 2'(idx), 5'b0};
      for (int w = 0; w < 4; w++)
        expWbData[w*64 +: 64] = shadow[{refTag[idx][vic], 2'(idx)}][w];
      refValid[idx][vic] = 1'b1;
      refTag[idx][vic] = 5'(tag);
      refDirty[idx][vic] = wr;
    end else if (wr) refDirty[idx][vic] = 1'b1;
    refLru[idx] = ~vic;
    if (wr) shadow[blk][ws] = data;

    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWData = data;
    @(negedge clk);
    reqValid = 1'b0;
    for (int t = 0; t < 60 && !gotRsp; t++) begin
      if (rspValid) begin gotRsp = 1; got = rspRData; end
      else begin
        if (reqReady) readyBad = 1;
        @(negedge clk);
      end
    end
    chk(gotRsp, "R10", "response arrives", 256'(gotRsp), 256'(1));
    chk(!readyBad && !reqReady, "R10", "ready low while busy", 256'(readyBad), 256'(0));
    @(negedge clk);
    chk(reqReady && !rspValid, "R10", "single pulse then idle", 256'({reqReady, rspValid}), 256'(2'b10));
    if (!wr)
      chk(got == shadow[blk][ws], expHit ? "R3" : "R9", "load data", 256'(got), 256'(shadow[blk][ws]));
    chk(wrCnt - w0 == int'(expWb), expHit ? "R4" : "R6", "write-back count", 256'(wrCnt - w0), 256'(expWb));
    chk(rdCnt - r0 == int'(!expHit), expHit ? "R3" : "R7", "fill count", 256'(rdCnt - r0), 256'(!expHit));
    if (!expHit)
      chk(lastRdAddr == {5'(tag), 2'(idx), 5'b0}, "R7", "fill address", 256'(lastRdAddr), 256'({5'(tag), 2'(idx), 5'b0}));
    if (expWb) begin
      chk(lastWrAddr == expWbAddr, "R5", "victim write-back address", 256'(lastWrAddr), 256'(expWbAddr));
      chk(lastWrData == expWbData, "R6", "write-back block", lastWrData, expWbData);
      chk(wrCyc < rdCyc, "R11", "write-back before fill", 256'(wrCyc), 256'(rdCyc));
    end
  endtask

  initial begin
    for (int b = 0; b < 128; b++)
      for (int w = 0; w < 4; w++) begin
        mem[b][w*64 +: 64] = initWord(b, w);
        shadow[b][w] = initWord(b, w);
      end
    for (int s = 0; s < 4; s++) begin
      refValid[s] = '0; refDirty[s] = '0; refLru[s] = 1'b0;
    end
    void'($urandom(32'd7731));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(reqReady && !rspValid && !memReqValid, "R2", "reset outputs",
        256'({reqReady, rspValid, memReqValid}), 256'(3'b100));
    access(0, 12'h000, '0);               // R2 R9 compulsory load miss
    access(0, 12'h008, '0);               // R3 hit
    access(0, 12'h00D, '0);               // R1 low bits ignored
    access(1, 12'h013, 64'hDEAD_BEEF_0001); // R4 R1 store hit
    access(0, 12'h010, '0);               // R4 readback
    access(1, 12'h198, 64'h1111_2222_3333); // R8 store miss into way 1
    access(0, 12'h180, '0);               // R8 other words from memory
    access(0, 12'h198, '0);               // R8 merged word
    access(0, 12'h080, '0);               // R5 R6 evicts dirty way 0, R11
    access(0, 12'h010, '0);               // R6 evicted store now from memory
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a = {2'b00, 3'($urandom), 2'($urandom), 2'($urandom), 3'($urandom)};
      bit wr = ($urandom % 2) == 1;
      access(wr, a, {$urandom, $urandom});
    end
    for (int b = 0; b < 32; b++)
      for (int w = 0; w < 4; w++)
        access(0, {5'(b >> 2), 2'(b), 2'(w), 3'b0}, '0); // R6 R9 readback sweep
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycle > 150000);
    checks++; fails++;
    $display("FAIL watchdog expired: actual %0d expected < 150000", cycle);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule